// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block implements a two-address indexed register window on an 8-bit I/O bus. Software writes a register number to the index address. It then reads or writes the chosen register through the data address, which is the next address up. The block holds a small bank of control bytes: three control registers, three address-region bytes, a performance byte, a fourth control byte and a power byte. It also returns two read-only identification bytes. The contents of the writable registers are driven straight out to the logic they configure.

Each data access must be preceded by its own index write. A data access that comes out of sequence, or that names a register that is not present or not visible, changes nothing inside the block. It returns FFh and raises an external-cycle flag so the system can pass the cycle to the outside bus. The extended registers are visible only while a map field in control register 3 holds 0001. A lock bit in control register 3 freezes three bits of control register 1. Once set, the lock bit can be cleared only in system-management mode or by reset.

Top module: `cfg_index_port`

## Requirements
- R1: A write to the index address (BASE_ADDR) captures the index byte and arms a pending flag. A read of the index address returns FFh, raises ext_cycle_o in that cycle and leaves the pending flag unchanged.
- R2: A data access at BASE_ADDR+1 is in sequence only while the pending flag is armed. Every data access clears the flag, so a second data access without a fresh index write is out of sequence.
- R3: An out-of-sequence data access, or one whose index is not implemented or not visible, changes no register, returns FFh and raises ext_cycle_o during that strobe cycle. Indices C0h and C4h are not implemented.
- R4: A claimed data read returns the selected register on io_rdata_o in the same cycle as the read strobe, with ext_cycle_o low. A claimed write updates the register at that clock edge.
- R5: The map field is control register 3 bits 7-4. With value 0001, indices 20h (performance), E8h (control 4) and F0h (power) are claimed. With any other value, only C1h, C2h, C3h, CDh, CEh, CFh, FEh and FFh are claimed.
- R6: While control register 3 bit 0 (lock) is 1, writes to control register 1 (C1h) leave bits 7, 2 and 1 unchanged and update the other bits.
- R7: A write to C3h can set the lock bit at any time, but can clear it only while smm_i is 1. Reset clears it.
- R8: FEh reads DEV_ID. FFh reads REV_STEP, with stepping in bits 7-4 and revision in bits 3-0. Writes to either index are accepted without ext_cycle_o and leave the value unchanged.
- R9: After reset, all writable registers are 00h and no index is pending.
- R10: An access to any address other than the index or data address leaves the pending flag unchanged, does not raise ext_cycle_o and reads FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | I/O address |
| io_rd_i | input | 1 | Read strobe, one cycle per access |
| io_wr_i | input | 1 | Write strobe, one cycle per access |
| io_wdata_i | input | 8 | Write data |
| smm_i | input | 1 | System-management mode active |
| io_rdata_o | output | 8 | Read data (FFh when not claimed) |
| ext_cycle_o | output | 1 | Access on own ports not claimed; forward externally |
| ctl1_o | output | 8 | Control register 1 (C1h) |
| ctl2_o | output | 8 | Control register 2 (C2h) |
| ctl3_o | output | 8 | Control register 3 (C3h): map field and lock |
| ctl4_o | output | 8 | Control register 4 (E8h) |
| perf_o | output | 8 | Performance byte (20h) |
| pwr_o | output | 8 | Power byte (F0h) |
| region_o | output | 24 | Region bytes {CDh, CEh, CFh} |

## Verification
The assertions watch on every cycle that an index write arms the pending flag and any data access clears it. They also check that foreign addresses leave the flag alone, that a cycle flagged as external leaves every register output stable, that the lock freezes the three guarded bits, and that the lock bit cannot drop outside system-management mode. The bench scenarios cover what needs a known register history. These are the read-back values, the FFh return on rejected cycles, visibility switching with the map field (including a value other than 0000 and 0001), the identification bytes, and the clearing of the lock under smm_i and by reset.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_RGN = 3;

  typedef enum logic [3:0] {
    K_NONE, K_CTL1, K_CTL2, K_CTL3, K_RGN, K_PERF, K_CTL4, K_PWR, K_ID0, K_ID1
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] sub;
    logic       ext_grp;
  } sel_t;

  localparam logic [3:0] MAP_ALL = 4'b0001;
  localparam logic [7:0] LOCK_MASK = 8'h86;

  function automatic sel_t decode_idx(input logic [DATA_W-1:0] idx);
    sel_t s;
    s.kind = K_NONE;
    s.sub = 2'd0;
    s.ext_grp = 1'b0;
    case (idx)
      8'hC1: s.kind = K_CTL1;
      8'hC2: s.kind = K_CTL2;
      8'hC3: s.kind = K_CTL3;
      8'hCD, 8'hCE, 8'hCF: begin
        s.kind = K_RGN;
        s.sub  = idx[1:0] - 2'd1;
      end
      8'h20: begin s.kind = K_PERF; s.ext_grp = 1'b1; end
      8'hE8: begin s.kind = K_CTL4; s.ext_grp = 1'b1; end
      8'hF0: begin s.kind = K_PWR;  s.ext_grp = 1'b1; end
      8'hFE: s.kind = K_ID0;
      8'hFF: s.kind = K_ID1;
      default: s.kind = K_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0022
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [7:0]        io_wdata_i,
  output logic              hit_idx_o,
  output logic              data_acc_o,
  output logic              in_seq_o,
  output logic [7:0]        index_o
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR + 1'b1);

  logic pending_q;
  logic [7:0] index_q;
  logic hit_dat, idx_wr;

  assign hit_idx_o  = (io_addr_i == BASE_ADDR);
  assign hit_dat    = (io_addr_i == DATA_ADDR);
  assign idx_wr     = hit_idx_o & io_wr_i;
  assign data_acc_o = hit_dat & (io_rd_i | io_wr_i);
  assign in_seq_o   = data_acc_o & pending_q;
  assign index_o    = index_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      index_q   <= '0;
    end else if (idx_wr) begin
      pending_q <= 1'b1;
      index_q   <= io_wdata_i;
    end else if (data_acc_o) begin
      pending_q <= 1'b0;
    end
  end

  assert_index_arms_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> pending_q);
  assert_data_disarms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc_o |=> !pending_q);
  assert_foreign_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_idx_o && !hit_dat) |=> (pending_q == $past(pending_q)));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] DEV_ID   = 8'h3C,
  parameter logic [7:0] REV_STEP = 8'h21
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  sel_t                    sel_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    smm_i,
  output logic [DATA_W-1:0]       rd_val_o,
  output logic [3:0]              map_o,
  output logic [DATA_W-1:0]       ctl1_o,
  output logic [DATA_W-1:0]       ctl2_o,
  output logic [DATA_W-1:0]       ctl3_o,
  output logic [DATA_W-1:0]       ctl4_o,
  output logic [DATA_W-1:0]       perf_o,
  output logic [DATA_W-1:0]       pwr_o,
  output logic [NUM_RGN*DATA_W-1:0] region_o
);
  logic [DATA_W-1:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q, perf_q, pwr_q;
  logic [DATA_W-1:0] rgn_q [NUM_RGN];
  logic lock;

  assign lock = ctl3_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q <= '0; ctl2_q <= '0; ctl3_q <= '0;
      ctl4_q <= '0; perf_q <= '0; pwr_q  <= '0;
    end else if (we_i) begin
      case (sel_i.kind)
        K_CTL1: ctl1_q <= lock ? ((ctl1_q & LOCK_MASK) | (wdata_i & ~LOCK_MASK)) : wdata_i;
        K_CTL2: ctl2_q <= wdata_i;
        // lock sticks unless in system-management mode
        K_CTL3: ctl3_q <= {wdata_i[7:1], wdata_i[0] | (lock & ~smm_i)};
        K_CTL4: ctl4_q <= wdata_i;
        K_PERF: perf_q <= wdata_i;
        K_PWR:  pwr_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rgn_q[g] <= '0;
      else if (we_i && sel_i.kind == K_RGN && sel_i.sub == 2'(g)) rgn_q[g] <= wdata_i;
    end
    assign region_o[(NUM_RGN-1-g)*DATA_W +: DATA_W] = rgn_q[g];
  end

  always_comb begin
    rd_val_o = 8'hFF;
    case (sel_i.kind)
      K_CTL1: rd_val_o = ctl1_q;
      K_CTL2: rd_val_o = ctl2_q;
      K_CTL3: rd_val_o = ctl3_q;
      K_CTL4: rd_val_o = ctl4_q;
      K_PERF: rd_val_o = perf_q;
      K_PWR:  rd_val_o = pwr_q;
      K_ID0:  rd_val_o = DEV_ID;
      K_ID1:  rd_val_o = REV_STEP;
      K_RGN: begin
        for (int i = 0; i < NUM_RGN; i++)
          if (sel_i.sub == 2'(i)) rd_val_o = rgn_q[i];
      end
      default: rd_val_o = 8'hFF;
    endcase
  end

  assign map_o  = ctl3_q[7:4];
  assign ctl1_o = ctl1_q;
  assign ctl2_o = ctl2_q;
  assign ctl3_o = ctl3_q;
  assign ctl4_o = ctl4_q;
  assign perf_o = perf_q;
  assign pwr_o  = pwr_q;

  assert_lock_freezes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i.kind == K_CTL1 && lock) |=> ((ctl1_q & LOCK_MASK) == ($past(ctl1_q) & LOCK_MASK)));
  assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && !smm_i) |=> ctl3_q[0]);
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0022,
  parameter logic [7:0] DEV_ID   = 8'h3C,
  parameter logic [7:0] REV_STEP = 8'h21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [7:0]        io_wdata_i,
  input  logic              smm_i,
  output logic [7:0]        io_rdata_o,
  output logic              ext_cycle_o,
  output logic [7:0]        ctl1_o,
  output logic [7:0]        ctl2_o,
  output logic [7:0]        ctl3_o,
  output logic [7:0]        ctl4_o,
  output logic [7:0]        perf_o,
  output logic [7:0]        pwr_o,
  output logic [23:0]       region_o
);
  logic hit_idx, data_acc, in_seq, claimed, visible;
  logic [7:0] index, rd_val;
  logic [3:0] map;
  sel_t sel;

  cfg_seq #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_seq (
    .clk_i, .rst_ni, .io_addr_i, .io_rd_i, .io_wr_i, .io_wdata_i,
    .hit_idx_o(hit_idx), .data_acc_o(data_acc), .in_seq_o(in_seq), .index_o(index)
  );

  assign sel     = decode_idx(index);
  assign visible = (sel.kind != K_NONE) && (!sel.ext_grp || map == MAP_ALL);
  assign claimed = in_seq & visible;

  cfg_regbank #(.DEV_ID(DEV_ID), .REV_STEP(REV_STEP)) u_bank (
    .clk_i, .rst_ni, .we_i(claimed & io_wr_i), .sel_i(sel), .wdata_i(io_wdata_i),
    .smm_i, .rd_val_o(rd_val), .map_o(map), .ctl1_o, .ctl2_o, .ctl3_o,
    .ctl4_o, .perf_o, .pwr_o, .region_o
  );

  assign io_rdata_o  = (claimed && io_rd_i) ? rd_val : 8'hFF;
  assign ext_cycle_o = (data_acc & ~claimed) | (hit_idx & io_rd_i);

  assert_ext_untouched_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cycle_o |=> $stable({ctl1_o, ctl2_o, ctl3_o, ctl4_o, perf_o, pwr_o, region_o}));
endmodule

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;
  localparam logic [15:0] IDX = 16'h0022;
  localparam logic [15:0] DAT = 16'h0023;

  logic clk_i = 0, rst_ni = 0;
  logic [15:0] io_addr_i = '0;
  logic io_rd_i = 0, io_wr_i = 0, smm_i = 0;
  logic [7:0] io_wdata_i = '0, io_rdata_o;
  logic ext_cycle_o;
  logic [7:0] ctl1_o, ctl2_o, ctl3_o, ctl4_o, perf_o, pwr_o;
  logic [23:0] region_o;
  int n_chk = 0, n_bad = 0;
  logic done = 0;

  cfg_index_port dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic rd, input logic [7:0] d,
                     output logic [7:0] q, output logic x);
    @(negedge clk_i);
    io_addr_i = a; io_rd_i = rd; io_wr_i = ~rd; io_wdata_i = d;
    #2; q = io_rdata_o; x = ext_cycle_o;
    @(posedge clk_i); #1;
    io_rd_i = 0; io_wr_i = 0; io_addr_i = 16'h0100;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, output logic x);
    logic [7:0] q;
    bus(a, 1'b0, d, q, x);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] q, output logic x);
    bus(a, 1'b1, 8'h00, q, x);
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d, output logic x);
    logic x0;
    wr(IDX, i, x0);
    wr(DAT, d, x);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] q, output logic x);
    logic x0;
    wr(IDX, i, x0);
    rd(DAT, q, x);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic t_reset();
    logic [7:0] q; logic x;
    chk("R9 ctl outputs", {ctl1_o, ctl2_o, ctl3_o, ctl4_o}, 32'h0);
    chk("R9 other outputs", {perf_o, pwr_o, region_o[15:0]}, 32'h0);
    rd(DAT, q, x);
    chk("R9 no pending after reset", {q, 7'd0, x}, {8'hFF, 7'd0, 1'b1});
    reg_rd(8'hC2, q, x);
    chk("R4 read C2 reset value", {q, 7'd0, x}, 16'h0000);
  endtask

  task automatic t_seq();
    logic [7:0] q; logic x;
    reg_wr(8'hC2, 8'h5A, x);
    chk("R4 write C2", {ctl2_o, 7'd0, x}, {8'h5A, 8'h00});
    wr(DAT, 8'hA5, x);
    chk("R2 second write out of sequence", {ctl2_o, 7'd0, x}, {8'h5A, 8'h01});
    reg_rd(8'hC2, q, x);
    chk("R4 read C2", {q, 7'd0, x}, {8'h5A, 8'h00});
    rd(DAT, q, x);
    chk("R2 second read out of sequence", {q, 7'd0, x}, {8'hFF, 8'h01});
    wr(IDX, 8'hCE, x);
    chk("R1 index write claimed", {31'd0, x}, 32'd0);
    rd(IDX, q, x);
    chk("R1 index read external", {q, 7'd0, x}, {8'hFF, 8'h01});
    wr(16'h0080, 8'h11, x);
    chk("R10 foreign write not external", {31'd0, x}, 32'd0);
    rd(16'h0024, q, x);
    chk("R10 foreign read", {q, 7'd0, x}, {8'hFF, 8'h00});
    wr(DAT, 8'h3C, x);
    chk("R1 R10 pending kept, region CE", {region_o, 7'd0, x}, {24'h003C00, 8'h00});
    reg_rd(8'hCE, q, x);
    chk("R4 read region", {q, 7'd0, x}, {8'h3C, 8'h00});
  endtask

  task automatic t_unimpl();
    logic [7:0] q; logic x;
    reg_wr(8'hC0, 8'h77, x);
    chk("R3 write C0 external", {31'd0, x}, 32'd1);
    reg_rd(8'hC4, q, x);
    chk("R3 read C4 external", {q, 7'd0, x}, {8'hFF, 8'h01});
    chk("R3 nothing written", {ctl1_o, ctl3_o, ctl4_o, perf_o}, 32'h0);
  endtask

  task automatic t_map();
    logic [7:0] q; logic x;
    reg_wr(8'h20, 8'h83, x);
    chk("R5 perf hidden map 0", {perf_o, 7'd0, x}, {8'h00, 8'h01});
    reg_wr(8'hC3, 8'h10, x);
    reg_wr(8'h20, 8'h83, x);
    chk("R5 perf visible", {perf_o, 7'd0, x}, {8'h83, 8'h00});
    reg_wr(8'hE8, 8'h11, x);
    reg_wr(8'hF0, 8'h03, x);
    chk("R5 ctl4 pwr", {ctl4_o, pwr_o}, {8'h11, 8'h03});
    reg_rd(8'hE8, q, x);
    chk("R5 read ctl4", {q, 7'd0, x}, {8'h11, 8'h00});
    reg_wr(8'hC3, 8'h20, x);
    reg_rd(8'hF0, q, x);
    chk("R5 map 0010 hides pwr", {q, 7'd0, x}, {8'hFF, 8'h01});
    reg_rd(8'hC3, q, x);
    chk("R5 ctl3 still visible", {q, 7'd0, x}, {8'h20, 8'h00});
    reg_wr(8'hC3, 8'h00, x);
  endtask

  task automatic t_lock();
    logic x;
    reg_wr(8'hC1, 8'h86, x);
    reg_wr(8'hC3, 8'h01, x);
    reg_wr(8'hC1, 8'h00, x);
    chk("R6 locked bits hold ones", {24'd0, ctl1_o}, 32'h86);
    reg_wr(8'hC1, 8'h79, x);
    chk("R6 unlocked bits written", {24'd0, ctl1_o}, 32'hFF);
    reg_wr(8'hC3, 8'h00, x);
    chk("R7 lock not cleared outside smm", {24'd0, ctl3_o}, 32'h01);
    smm_i = 1;
    reg_wr(8'hC3, 8'h00, x);
    smm_i = 0;
    chk("R7 lock cleared in smm", {24'd0, ctl3_o}, 32'h00);
    reg_wr(8'hC1, 8'h00, x);
    chk("R6 unlocked write all bits", {24'd0, ctl1_o}, 32'h00);
    reg_wr(8'hC3, 8'h01, x);
    do_reset();
    chk("R7 R9 reset clears lock", {ctl1_o, ctl2_o, ctl3_o, perf_o}, 32'h0);
  endtask

  task automatic t_id();
    logic [7:0] q; logic x;
    reg_rd(8'hFE, q, x);
    chk("R8 device id", {q, 7'd0, x}, {8'h3C, 8'h00});
    reg_rd(8'hFF, q, x);
    chk("R8 stepping revision", {q, 7'd0, x}, {8'h21, 8'h00});
    reg_wr(8'hFE, 8'h00, x);
    chk("R8 id write no external", {31'd0, x}, 32'd0);
    reg_rd(8'hFE, q, x);
    chk("R8 id unchanged", {24'd0, q}, 32'h3C);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        t_reset();
        t_seq();
        t_unimpl();
        t_map();
        t_lock();
        t_id();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule